// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block controls the movement of data between a volatile SRAM array and its nonvolatile shadow copy. Both arrays are modelled as register arrays inside the block. A STORE copies every SRAM word into the shadow copy. A RECALL copies every shadow word back into SRAM. Host reads and writes go to the SRAM through a simple request port.

Five request sources drive one shared copy engine:
- a rising edge on the power-fail indication, which starts a store;
- a falling edge on the active-low hardware store input, which starts a store;
- a power-up pulse, which starts a recall;
- a software store strobe;
- a software recall strobe.

The engine arbitrates between these sources and cannot be interrupted once it starts. While it runs, it raises `busy` and drives the hardware store output low. Each operation lasts a programmable number of clock cycles, and the word copy takes the first 2^ADDR_W of those cycles. A counter records the number of completed stores.

After reset, the SRAM holds no valid data. The host port is refused until the first recall completes. Until then, only the power-up request is honoured.

Top module: `nvseq_top`

## Requirements
- R1: Until the first recall completes after reset, every host access is refused (`memRefused`=1, no write takes effect, no `memRdValid`), and store or software recall requests start no operation (`busy` stays 0).
- R2: A one-cycle pulse on `powerUp` starts a recall. After it, SRAM reads return the shadow contents, which are all zero after reset.
- R3: A 0-to-1 transition of `powerFail` starts a store. Holding `powerFail` high starts no further operation.
- R4: A 1-to-0 transition of `hwStoreInN` starts a store. Holding it low starts no further operation.
- R5: A `swStore` strobe starts a store, and a `swRecall` strobe starts a recall, once the first recall has completed.
- R6: A store copies all 2^ADDR_W SRAM words into the shadow array. A recall copies all of them back into SRAM.
- R7: `busy` rises on the clock edge that accepts a request and stays high for exactly OP_CYCLES cycles. `hwStoreOutN` is 0 exactly while `busy` is 1.
- R8: While `busy` is 1, host accesses are refused with `memRefused`=1. Writes do not change the SRAM, and reads produce no `memRdValid`.
- R9: When several requests are accepted on the same edge, priority runs from highest to lowest as follows: power-fail store, hardware-pin store, power-up recall, software store, software recall.
- R10: Any request that arrives while `busy` is 1 is dropped. It is not queued and does not alter the running operation.
- R11: `storeCount` increments by one on the edge where a store finishes. Recalls leave it unchanged. It is 0 after reset.
- R12: An accepted read (`memValid`=1, `memWe`=0) produces `memRdValid`=1 on the next cycle, with the SRAM word at `memAddr` on `memRdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerFail | input | 1 | Power-down indication; a rising edge requests a store |
| powerUp | input | 1 | Power-up pulse; requests a recall |
| hwStoreInN | input | 1 | Active-low hardware store input; a falling edge requests a store |
| swStore | input | 1 | Software store strobe |
| swRecall | input | 1 | Software recall strobe |
| memValid | input | 1 | Host access request |
| memWe | input | 1 | 1 = write, 0 = read |
| memAddr | input | ADDR_W | Host word address |
| memWdata | input | DATA_W | Host write data |
| memRdata | output | DATA_W | Read data |
| memRdValid | output | 1 | Read data valid, one cycle after an accepted read |
| memRefused | output | 1 | Host request refused in this cycle |
| busy | output | 1 | A store or recall is running |
| hwStoreOutN | output | 1 | Driven low while an operation runs |
| storeCount | output | CNT_W | Number of completed stores |

## Verification
On every cycle, the assertions check the following:
- the step-by-step progress of the operation counter;
- the exact cycle on which `busy` drops;
- that the operation type stays fixed while the engine runs;
- the store counter's update and hold rules;
- that host reads and writes never coincide with a copy step or with the pre-recall lock.

Only the bench scenarios can show that the data actually moves between the arrays, through a write, store, overwrite, recall and read-back sequence. The bench scenarios also cover edge versus level behaviour on the power-fail and hardware store inputs, the winner among simultaneous requests, and the dropping of requests made mid-operation.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  // Strobes passed from the sequencer control to the array datapath.
  typedef struct packed {
    logic busy;    // engine running, host port closed
    logic ready;   // first recall done, host port may open
    logic copyEn;  // move one word this cycle
    logic toNv;    // 1: SRAM -> shadow, 0: shadow -> SRAM
  } nvStrobe_t;

  // Request vector bit order, index 0 wins.
  localparam int REQ_PF   = 0;
  localparam int REQ_HW   = 1;
  localparam int REQ_PU   = 2;
  localparam int REQ_SWST = 3;
  localparam int REQ_SWRC = 4;
  localparam int REQ_N    = 5;

endpackage

// File: rtl/nvseq_arb.sv
module nvseq_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] reqVec,
  output logic [N-1:0] grantVec,
  output logic         anyGrant
);

  always_comb begin
    grantVec = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        grantVec    = '0;
        grantVec[i] = 1'b1;
      end
    end
  end

  assign anyGrant = |reqVec;

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int OP_CYCLES = 80,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              powerUp,
  input  logic              hwStoreInN,
  input  logic              swStore,
  input  logic              swRecall,
  output nvStrobe_t         strobe,
  output logic [ADDR_W-1:0] copyIdx,
  output logic [CNT_W-1:0]  storeCount
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int OPC_W = $clog2(OP_CYCLES + 1);
  localparam logic [OPC_W-1:0] LAST_STEP = OPC_W'(OP_CYCLES - 1);
  localparam logic [OPC_W-1:0] COPY_END  = OPC_W'(DEPTH);

  logic             busyQ, opStoreQ, readyQ;
  logic [OPC_W-1:0] stepQ;
  logic             pfPrevQ, hwPrevQ;

  logic [REQ_N-1:0] rawReq, validReq, grantVec;
  logic             anyGrant, grantStore, lastStep;

  // Edge detection on the level-type triggers.
  always_comb begin
    rawReq           = '0;
    rawReq[REQ_PF]   = powerFail & ~pfPrevQ;
    rawReq[REQ_HW]   = ~hwStoreInN & hwPrevQ;
    rawReq[REQ_PU]   = powerUp;
    rawReq[REQ_SWST] = swStore;
    rawReq[REQ_SWRC] = swRecall;
  end

  // Before the first recall only power-up counts; while busy nothing counts.
  always_comb begin
    validReq = '0;
    if (!busyQ) begin
      if (readyQ) validReq = rawReq;
      else        validReq[REQ_PU] = rawReq[REQ_PU];
    end
  end

  nvseq_arb #(.N(REQ_N)) arb_i (
    .reqVec  (validReq),
    .grantVec(grantVec),
    .anyGrant(anyGrant)
  );

  assign grantStore = grantVec[REQ_PF] | grantVec[REQ_HW] | grantVec[REQ_SWST];
  assign lastStep   = busyQ && (stepQ == LAST_STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfPrevQ <= 1'b0;
      hwPrevQ <= 1'b1;
    end else begin
      pfPrevQ <= powerFail;
      hwPrevQ <= hwStoreInN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      opStoreQ   <= 1'b0;
      readyQ     <= 1'b0;
      stepQ      <= '0;
      storeCount <= '0;
    end else if (busyQ) begin
      if (lastStep) begin
        busyQ <= 1'b0;
        stepQ <= '0;
        if (opStoreQ) storeCount <= storeCount + 1'b1;
        else          readyQ     <= 1'b1;
      end else begin
        stepQ <= stepQ + 1'b1;
      end
    end else if (anyGrant) begin
      busyQ    <= 1'b1;
      opStoreQ <= grantStore;
      stepQ    <= '0;
    end
  end

  assign strobe.busy   = busyQ;
  assign strobe.ready  = readyQ;
  assign strobe.copyEn = busyQ && (stepQ < COPY_END);
  assign strobe.toNv   = opStoreQ;
  assign copyIdx       = stepQ[ADDR_W-1:0];

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastStep) |=> (busyQ && stepQ == $past(stepQ) + 1'b1)); // R7
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    lastStep |=> !busyQ); // R7
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastStep) |=> $stable(opStoreQ)); // R10
  AST_COUNT_BUMP: assert property (@(posedge clk) disable iff (!rstN)
    (lastStep && opStoreQ) |=> storeCount == $past(storeCount) + 1'b1); // R11
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(lastStep && opStoreQ) |=> $stable(storeCount)); // R11
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R9
  AST_LOCKED_START: assert property (@(posedge clk) disable iff (!rstN)
    (!readyQ && !busyQ && anyGrant) |=> !opStoreQ); // R1

endmodule

// File: rtl/nvseq_data.sv
module nvseq_data
  import nvseq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvStrobe_t         strobe,
  input  logic [ADDR_W-1:0] copyIdx,
  input  logic              memValid,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] memRdata,
  output logic              memRdValid,
  output logic              memRefused
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sramArr [DEPTH];
  logic [DATA_W-1:0] nvArr   [DEPTH];

  logic hostOk, hostWr, hostRd;

  assign hostOk     = strobe.ready && !strobe.busy;
  assign hostWr     = memValid && memWe && hostOk;
  assign hostRd     = memValid && !memWe && hostOk;
  assign memRefused = memValid && !hostOk;

  // Volatile array: filled by recall, no reset.
  always_ff @(posedge clk) begin
    if (strobe.copyEn && !strobe.toNv)
      sramArr[copyIdx] <= nvArr[copyIdx];
    else if (hostWr)
      sramArr[memAddr] <= memWdata;
  end

  // Shadow array: cleared by reset so the first recall is defined.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) nvArr[i] <= '0;
    end else if (strobe.copyEn && strobe.toNv) begin
      nvArr[copyIdx] <= sramArr[copyIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memRdata   <= '0;
      memRdValid <= 1'b0;
    end else begin
      memRdValid <= hostRd;
      if (hostRd) memRdata <= sramArr[memAddr];
    end
  end

  AST_NO_HOST_IN_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.copyEn |-> !(hostWr || hostRd)); // R8
  AST_LOCKED_HOST: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ready |-> !(hostWr || hostRd)); // R1
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> memRdValid); // R12
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> !memRdValid); // R12

endmodule

// File: rtl/nvseq_top.sv
module nvseq_top
  import nvseq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int OP_CYCLES = 80,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              powerUp,
  input  logic              hwStoreInN,
  input  logic              swStore,
  input  logic              swRecall,
  input  logic              memValid,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] memRdata,
  output logic              memRdValid,
  output logic              memRefused,
  output logic              busy,
  output logic              hwStoreOutN,
  output logic [CNT_W-1:0]  storeCount
);

  // OP_CYCLES must be at least 2**ADDR_W so a whole array fits in one operation.

  nvStrobe_t         strobe;
  logic [ADDR_W-1:0] copyIdx;

  nvseq_ctrl #(.ADDR_W(ADDR_W), .OP_CYCLES(OP_CYCLES), .CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .powerFail (powerFail),
    .powerUp   (powerUp),
    .hwStoreInN(hwStoreInN),
    .swStore   (swStore),
    .swRecall  (swRecall),
    .strobe    (strobe),
    .copyIdx   (copyIdx),
    .storeCount(storeCount)
  );

  nvseq_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .copyIdx   (copyIdx),
    .memValid  (memValid),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRdata  (memRdata),
    .memRdValid(memRdValid),
    .memRefused(memRefused)
  );

  assign busy        = strobe.busy;
  assign hwStoreOutN = ~strobe.busy;

  AST_PIN_LOW_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !hwStoreOutN); // R7
  AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memValid) |-> memRefused); // R8

endmodule

// File: tb/nvseq_top_tb_top.sv
module nvseq_top_tb_top;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int OPC    = 20;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerFail = 1'b0, powerUp = 1'b0, hwStoreInN = 1'b1;
  logic swStore = 1'b0, swRecall = 1'b0;
  logic memValid = 1'b0, memWe = 1'b0;
  logic [ADDR_W-1:0] memAddr = '0;
  logic [DATA_W-1:0] memWdata = '0;
  logic [DATA_W-1:0] memRdata;
  logic memRdValid, memRefused, busy, hwStoreOutN;
  logic [CNT_W-1:0] storeCount;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  nvseq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_CYCLES(OPC), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .powerUp(powerUp),
    .hwStoreInN(hwStoreInN), .swStore(swStore), .swRecall(swRecall),
    .memValid(memValid), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRdValid(memRdValid), .memRefused(memRefused),
    .busy(busy), .hwStoreOutN(hwStoreOutN), .storeCount(storeCount)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever read data returns.
  always @(negedge clk) begin
    if (rstN && memRdValid) begin
      if (expQ.size() == 0) check("R12 unexpected read data", 1, 0);
      else check(tagQ.pop_front(), memRdata, expQ.pop_front());
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeWord(input int a, input int d);
    memValid = 1'b1; memWe = 1'b1; memAddr = ADDR_W'(a); memWdata = DATA_W'(d);
    tick();
    memValid = 1'b0; memWe = 1'b0;
  endtask

  task automatic readWord(input int a, input int d, input string tag);
    memValid = 1'b1; memWe = 1'b0; memAddr = ADDR_W'(a);
    expQ.push_back(DATA_W'(d)); tagQ.push_back(tag);
    tick();
    memValid = 1'b0;
  endtask

  task automatic refusedRead(input int a, input string tag);
    memValid = 1'b1; memWe = 1'b0; memAddr = ADDR_W'(a);
    #1 check(tag, memRefused, 1);
    tick();
    memValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) tick();
    tick();
  endtask

  function automatic int patA(int i); return (i * 7 + 1) & 8'hFF; endfunction
  function automatic int patB(int i); return (i * 13 + 90) & 8'hFF; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int n;
    int cnt;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check("R11 reset count", storeCount, 0);
    check("R7 reset busy", busy, 0);
    check("R7 reset pin", hwStoreOutN, 1);

    // R1: locked before first recall
    refusedRead(2, "R1 refused before recall");
    check("R1 no read data", memRdValid, 0);
    swStore = 1'b1; swRecall = 1'b1; tick(); swStore = 1'b0; swRecall = 1'b0;
    check("R1 no start while locked", busy, 0);

    // R2/R7: power-up recall and its duration
    powerUp = 1'b1; tick(); powerUp = 1'b0;
    n = 0;
    while (busy) begin
      if (hwStoreOutN !== 1'b0) check("R7 pin low while busy", hwStoreOutN, 0);
      n++; tick();
    end
    check("R7 busy length", n, OPC);
    check("R7 pin released", hwStoreOutN, 1);
    check("R11 recall leaves count", storeCount, 0);
    readWord(3, 0, "R2 recall of cleared shadow");
    readWord(DEPTH - 1, 0, "R2 recall last word");

    // R5/R6/R8/R10: software store with mid-operation traffic
    for (int i = 0; i < DEPTH; i++) writeWord(i, patA(i));
    readWord(5, patA(5), "R12 read after write");
    swStore = 1'b1; tick(); swStore = 1'b0;
    check("R5 store started", busy, 1);
    refusedRead(1, "R8 refused while busy");
    memValid = 1'b1; memWe = 1'b1; memAddr = 4'd0; memWdata = 8'hEE;
    #1 check("R8 write refused", memRefused, 1);
    tick(); memValid = 1'b0; memWe = 1'b0;
    swRecall = 1'b1; tick(); swRecall = 1'b0;
    powerFail = 1'b1; tick(); powerFail = 1'b0;
    waitIdle();
    check("R11 count after store", storeCount, 1);
    check("R10 no queued op", busy, 0);
    readWord(0, patA(0), "R8 write during busy ignored");

    // R6: overwrite then recall restores stored image
    for (int i = 0; i < DEPTH; i++) writeWord(i, patB(i));
    readWord(4, patB(4), "R12 overwrite visible");
    swRecall = 1'b1; tick(); swRecall = 1'b0;
    check("R5 recall started", busy, 1);
    waitIdle();
    check("R11 recall leaves count", storeCount, 1);
    for (int i = 0; i < DEPTH; i++) readWord(i, patA(i), "R6 image restored");

    // R3: power-fail edge, level held
    writeWord(2, 8'h55);
    powerFail = 1'b1; tick();
    check("R3 power-fail store", busy, 1);
    waitIdle();
    repeat (5) tick();
    check("R3 no retrigger on level", busy, 0);
    check("R11 count after power-fail", storeCount, 2);
    powerFail = 1'b0; tick();

    // R4: hardware pin edge, level held
    hwStoreInN = 1'b0; tick();
    check("R4 pin store", busy, 1);
    waitIdle();
    repeat (5) tick();
    check("R4 no retrigger on level", busy, 0);
    check("R11 count after pin", storeCount, 3);
    hwStoreInN = 1'b1; tick();

    // R9: store beats recall among software strobes
    writeWord(7, 8'hA7);
    swStore = 1'b1; swRecall = 1'b1; tick(); swStore = 1'b0; swRecall = 1'b0;
    waitIdle();
    check("R9 sw store over sw recall", storeCount, 4);
    // R9: power-up recall beats software store
    writeWord(7, 8'h11);
    powerUp = 1'b1; swStore = 1'b1; tick(); powerUp = 1'b0; swStore = 1'b0;
    waitIdle();
    check("R9 power-up over sw store", storeCount, 4);
    readWord(7, 8'hA7, "R9 recall ran");
    // R9: hardware pin beats power-up
    hwStoreInN = 1'b0; powerUp = 1'b1; tick(); powerUp = 1'b0;
    waitIdle();
    hwStoreInN = 1'b1;
    check("R9 pin over power-up", storeCount, 5);
    cnt = 0;
    repeat (3) tick();
    check("R12 scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule